// File: doc/BRIEF.md
# Six-Channel Down-Counting Interval Timer

This block holds six independent down-counters behind a small word-addressed register bus. Each channel has a control word, an interval word that holds the reload value, and a current-count word that software can read and overwrite at any time. A channel counts down by one on each qualified tick. A qualified tick is one of four tick-enable inputs, chosen per channel, and then divided by a power of two. When the count expires, the channel raises its bit in a shared pending word. It then either reloads from its interval or halts and clears its own start bit.

All six channels share one interrupt line. A shared enable word selects which pending bits reach that line. Software clears pending bits by writing ones to them. The clock sources are not real clocks: each one is a tick-enable input that is sampled on the single block clock.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Register map, with word-aligned addresses only:
  - Enable word is at 0x00. Pending word is at 0x04. Bit k of each belongs to channel k.
  - Channel k has its control word at 0x10+0x10·k, its interval word at 0x14+0x10·k and its current count at 0x18+0x10·k.
  - Any other address, and any address whose two low bits are not zero, reads zero and ignores writes.
  - The control word reads back its 8 bits. The other words read back what was written.
- R3: Writing a one to a pending bit clears it, and writing a zero leaves it unchanged. If an expiry sets a bit in the same cycle that a write clears it, the bit stays set.
- R4: While control bit 0 (start) is set, the count drops by one on each qualified tick. While start is clear, the count holds.
- R5: A qualified tick that finds the count at 1 or 0 is an expiry, and it sets the channel's pending bit on that clock.
- R6: On expiry, the count reloads from the interval word when control bit 1 (reload) is 1 and control bit 7 (single mode) is 0.
- R7: On expiry in any other mode, the count becomes 0, the start bit clears and counting stops.
- R8: Control bits 3:2 pick which bit of `tickIn` is the channel's source. The value 1 picks `tickIn[1]`, the oscillator tick.
- R9: With control bits 6:4 equal to n, a qualified tick occurs once every 2^n source ticks, counted from the cycle the channel started.
- R10: `irq` is high exactly when some bit is set in both the enable word and the pending word.
- R11: A control write that sets start on a stopped channel whose count is 0 loads the count from the interval word. If the count is not 0, the count is kept.
- R12: A write to the current-count word takes effect on the next clock, even when a tick arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrEn | input | 1 | Write strobe for this cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| tickIn | input | 4 | Tick-enable sources; bit 1 is the oscillator tick |
| irq | output | 1 | Shared interrupt line |

## Verification
The assertions check on every cycle the structural rules that govern count, start bit and pending word:
- an expiry is always captured in the pending word;
- pending bits drop only on a write to the pending address;
- a stopped count holds;
- a running count moves by at most one per cycle;
- reload and halt on expiry follow the mode bits.

Only the bench's scenarios can show the timing-specific behaviour:
- the exact tick count to expiry;
- the prescaler ratio;
- which source a channel follows;
- the interval load on start;
- the write-versus-tick and clear-versus-set priorities.

For these, a behavioural model is compared against every readback and against `irq` on each clock.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W     = 32;
  localparam int CTRL_W     = 8;
  localparam int SRC_W      = 2;
  localparam int NUM_SRC    = 1 << SRC_W;
  localparam int PRE_W      = 3;
  localparam int PCNT_W     = (1 << PRE_W) - 1;
  localparam int START_BIT  = 0;
  localparam int RELOAD_BIT = 1;
  localparam int SRC_LSB    = 2;
  localparam int PRE_LSB    = 4;
  localparam int SINGLE_BIT = 7;

  // word offset inside a 16-byte slot
  localparam logic [1:0] OFF_EN   = 2'd0;
  localparam logic [1:0] OFF_PEND = 2'd1;
  localparam logic [1:0] OFF_CTRL = 2'd0;
  localparam logic [1:0] OFF_INTV = 2'd1;
  localparam logic [1:0] OFF_CUR  = 2'd2;

  typedef struct packed {
    logic wrCtrl;
    logic wrIntv;
    logic wrCur;
  } chanStrobe_t;
endpackage

// File: rtl/timer_chans.sv
module timer_chans
  import timer_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  chanStrobe_t [NUM_CH-1:0]          strobes,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic [NUM_SRC-1:0]                tickIn,
  output logic [NUM_CH-1:0][CTRL_W-1:0]     ctrlQ,
  output logic [NUM_CH-1:0][CNT_W-1:0]      intvQ,
  output logic [NUM_CH-1:0][CNT_W-1:0]      curQ,
  output logic [NUM_CH-1:0]                 expire
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CTRL_W-1:0] ctrlR;
    logic [CNT_W-1:0]  intvR;
    logic [CNT_W-1:0]  curR;
    logic [PCNT_W-1:0] preCnt;
    logic [SRC_W-1:0]  srcSel;
    logic [PRE_W-1:0]  preSel;
    logic [PCNT_W-1:0] preMask;
    logic running, srcTick, divTick, hit, reloadMode, startRise;

    assign running    = ctrlR[START_BIT];
    assign srcSel     = ctrlR[SRC_LSB +: SRC_W];
    assign preSel     = ctrlR[PRE_LSB +: PRE_W];
    assign preMask    = (PCNT_W'(1) << preSel) - PCNT_W'(1);
    assign srcTick    = tickIn[srcSel];
    assign divTick    = running & srcTick & ((preCnt & preMask) == preMask);
    assign hit        = divTick & (curR <= CNT_W'(1));
    assign reloadMode = ctrlR[RELOAD_BIT] & ~ctrlR[SINGLE_BIT];
    assign startRise  = strobes[c].wrCtrl & wrData[START_BIT] & ~running;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlR  <= '0;
        intvR  <= '0;
        curR   <= '0;
        preCnt <= '0;
      end else begin
        if (!running)     preCnt <= '0;
        else if (srcTick) preCnt <= preCnt + PCNT_W'(1);

        if (strobes[c].wrIntv) intvR <= wrData[CNT_W-1:0];

        if (strobes[c].wrCtrl)      ctrlR <= wrData[CTRL_W-1:0];
        else if (hit && !reloadMode) ctrlR[START_BIT] <= 1'b0;

        if (strobes[c].wrCur)             curR <= wrData[CNT_W-1:0];
        else if (startRise && curR == '0) curR <= intvR;
        else if (hit)                     curR <= reloadMode ? intvR : '0;
        else if (divTick)                 curR <= curR - CNT_W'(1);
      end
    end

    assign ctrlQ[c]  = ctrlR;
    assign intvQ[c]  = intvR;
    assign curQ[c]   = curR;
    assign expire[c] = hit;
  end
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWrEn,
  input  logic [NUM_CH-1:0]             wrBits,
  input  logic [NUM_CH-1:0][CTRL_W-1:0] ctrlQ,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  intvQ,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  curQ,
  input  logic [NUM_CH-1:0]             expire,
  output chanStrobe_t [NUM_CH-1:0]      strobes,
  output logic [NUM_CH-1:0]             enQ,
  output logic [NUM_CH-1:0]             pendQ,
  output logic [DATA_W-1:0]             busRdData,
  output logic                          irq
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        off;
  logic              aligned, globHit, wrEnReg, wrPendReg;

  assign slot      = busAddr[ADDR_W-1:4];
  assign off       = busAddr[3:2];
  assign aligned   = busAddr[1:0] == 2'b00;
  assign globHit   = aligned && slot == '0;
  assign wrEnReg   = busWrEn && globHit && off == OFF_EN;
  assign wrPendReg = busWrEn && globHit && off == OFF_PEND;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    logic chHit;
    assign chHit             = aligned && slot == SLOT_W'(c + 1);
    assign strobes[c].wrCtrl = busWrEn && chHit && off == OFF_CTRL;
    assign strobes[c].wrIntv = busWrEn && chHit && off == OFF_INTV;
    assign strobes[c].wrCur  = busWrEn && chHit && off == OFF_CUR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= '0;
      pendQ <= '0;
    end else begin
      if (wrEnReg) enQ <= wrBits;
      pendQ <= (pendQ & ~(wrPendReg ? wrBits : '0)) | expire;
    end
  end

  always_comb begin
    busRdData = '0;
    if (globHit) begin
      if (off == OFF_EN)   busRdData = DATA_W'(enQ);
      if (off == OFF_PEND) busRdData = DATA_W'(pendQ);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (aligned && slot == SLOT_W'(c + 1)) begin
        case (off)
          OFF_CTRL: busRdData = DATA_W'(ctrlQ[c]);
          OFF_INTV: busRdData = DATA_W'(intvQ[c]);
          OFF_CUR:  busRdData = DATA_W'(curQ[c]);
          default:  busRdData = '0;
        endcase
      end
    end
  end

  assign irq = |(enQ & pendQ);
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import timer_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_SRC-1:0]  tickIn,
  output logic                irq
);
  chanStrobe_t [NUM_CH-1:0]          strobes;
  logic [NUM_CH-1:0][CTRL_W-1:0]     ctrlQ;
  logic [NUM_CH-1:0][CNT_W-1:0]      intvQ;
  logic [NUM_CH-1:0][CNT_W-1:0]      curQ;
  logic [NUM_CH-1:0]                 expire;
  logic [NUM_CH-1:0]                 enQ;
  logic [NUM_CH-1:0]                 pendQ;

  timer_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .wrBits(busWrData[NUM_CH-1:0]), .ctrlQ(ctrlQ), .intvQ(intvQ), .curQ(curQ),
    .expire(expire), .strobes(strobes), .enQ(enQ), .pendQ(pendQ),
    .busRdData(busRdData), .irq(irq)
  );

  timer_chans #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chans (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWrData),
    .tickIn(tickIn), .ctrlQ(ctrlQ), .intvQ(intvQ), .curQ(curQ), .expire(expire)
  );
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [ADDR_W-1:0]            busAddr,
  input logic                         busWrEn,
  input logic [NUM_CH-1:0][7:0]       ctrlQ,
  input logic [NUM_CH-1:0][CNT_W-1:0] intvQ,
  input logic [NUM_CH-1:0][CNT_W-1:0] curQ,
  input logic [NUM_CH-1:0]            expire,
  input logic [NUM_CH-1:0]            pendQ
);
  // R5
  pend_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|expire) |=> ((pendQ & $past(expire)) == $past(expire)));

  // R3
  pend_w1c_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == ADDR_W'(4)) |=> ((pendQ & $past(pendQ)) == $past(pendQ)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R7
    halt_on_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
      (expire[c] && !(ctrlQ[c][1] && !ctrlQ[c][7]) && !busWrEn) |=> !ctrlQ[c][0]);

    // R6
    reload_value_chk: assert property (@(posedge clk) disable iff (!rstN)
      (expire[c] && ctrlQ[c][1] && !ctrlQ[c][7] && !busWrEn) |=> curQ[c] == $past(intvQ[c]));

    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!ctrlQ[c][0] && !busWrEn) |=> $stable(curQ[c]));

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlQ[c][0] && !busWrEn && curQ[c] > CNT_W'(1)) |=>
        (curQ[c] == $past(curQ[c]) || curQ[c] == $past(curQ[c]) - CNT_W'(1)));
  end
endmodule

bind tick_timer_bank timer_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .ctrlQ(ctrlQ),
  .intvQ(intvQ), .curQ(curQ), .expire(expire), .pendQ(pendQ)
);

// File: tb/tick_timer_bank_tb.sv
module tick_timer_bank_tb;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  tickIn;
  logic        irq;
  logic        oscOn = 1'b0;
  logic        slowOn = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign tickIn = {lfsr[3], slowOn, oscOn, lfsr[0]};

  tick_timer_bank u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .tickIn(tickIn), .irq(irq)
  );

  // behavioural reference state
  logic [31:0] mCtrl [NCH];
  logic [31:0] mIntv [NCH];
  logic [31:0] mCur  [NCH];
  int          mPc   [NCH];
  logic [5:0]  mEn, mPend;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mRead(logic [7:0] a);
    int slot = int'(a >> 4);
    int off  = int'((a >> 2) & 8'd3);
    if (a[1:0] != 2'b00) return 0;
    if (slot == 0) begin
      if (off == 0) return 32'(mEn);
      if (off == 1) return 32'(mPend);
      return 0;
    end
    if (slot <= NCH) begin
      if (off == 0) return mCtrl[slot-1];
      if (off == 1) return mIntv[slot-1];
      if (off == 2) return mCur[slot-1];
    end
    return 0;
  endfunction

  task automatic modelStep();
    logic [31:0] nCtrl [NCH];
    logic [31:0] nCur  [NCH];
    logic [5:0]  setP = '0;
    logic [5:0]  clrP = '0;
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin
        mCtrl[c] = 0; mIntv[c] = 0; mCur[c] = 0; mPc[c] = 0;
      end
      mEn = 0; mPend = 0;
      return;
    end
    for (int c = 0; c < NCH; c++) begin
      logic run, src, div;
      int sel, n, m;
      run = mCtrl[c][0];
      sel = int'(mCtrl[c][3:2]);
      n   = int'(mCtrl[c][6:4]);
      m   = (1 << n) - 1;
      src = tickIn[sel];
      nCtrl[c] = mCtrl[c];
      nCur[c]  = mCur[c];
      div = run && src && ((mPc[c] & m) == m);
      if (div) begin
        if (mCur[c] <= 1) begin
          setP[c] = 1'b1;
          if (mCtrl[c][1] && !mCtrl[c][7]) nCur[c] = mIntv[c];
          else begin nCur[c] = 0; nCtrl[c][0] = 1'b0; end
        end else nCur[c] = mCur[c] - 1;
      end
      if (!run) mPc[c] = 0;
      else if (src) mPc[c] = (mPc[c] + 1) % 128;
    end
    if (busWrEn && busAddr[1:0] == 2'b00) begin
      int slot = int'(busAddr >> 4);
      int off  = int'((busAddr >> 2) & 8'd3);
      if (slot == 0 && off == 0) mEn = busWrData[5:0];
      if (slot == 0 && off == 1) clrP = busWrData[5:0];
      if (slot >= 1 && slot <= NCH) begin
        if (off == 0) begin
          if (busWrData[0] && !mCtrl[slot-1][0] && mCur[slot-1] == 0) nCur[slot-1] = mIntv[slot-1];
          nCtrl[slot-1] = busWrData & 32'hFF;
        end
        if (off == 1) mIntv[slot-1] = busWrData;
        if (off == 2) nCur[slot-1] = busWrData;
      end
    end
    for (int c = 0; c < NCH; c++) begin
      mCtrl[c] = nCtrl[c];
      mCur[c]  = nCur[c];
    end
    mPend = (mPend & ~clrP) | setP;
  endtask

  always @(posedge clk) modelStep();

  // every-cycle comparison, taken mid-high-phase
  always @(posedge clk) begin
    #5;
    if (rstN) begin
      chk("R10 irq vs model", 32'(irq), 32'((mEn & mPend) != 0));
      chk("R2 readback vs model", busRdData, mRead(busAddr));
    end
  end

  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic expectReg(logic [7:0] a, logic [31:0] exp, string tag);
    busAddr = a;
    #1;
    chk(tag, busRdData, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    for (int a = 0; a < 8'h70; a += 4) expectReg(8'(a), 32'h0, "R1 reset value");
    chk("R1 irq after reset", 32'(irq), 32'h0);

    // R2 map and readback
    wrReg(8'h64, 32'hDEADBEEF);
    expectReg(8'h64, 32'hDEADBEEF, "R2 interval readback");
    expectReg(8'h6C, 32'h0, "R2 unmapped read");
    expectReg(8'h08, 32'h0, "R2 unmapped read");

    // channel 0: continuous reload, period 5
    wrReg(8'h14, 32'd5);
    wrReg(8'h10, 32'h06);
    expectReg(8'h18, 32'd0, "R11 no load without start");
    wrReg(8'h10, 32'h07);
    expectReg(8'h18, 32'd5, "R11 load on start");
    expectReg(8'h10, 32'h07, "R2 control readback");
    oscOn = 1'b1; idle(3); oscOn = 1'b0;
    expectReg(8'h18, 32'd2, "R4 count down");
    oscOn = 1'b1; idle(2); oscOn = 1'b0;
    expectReg(8'h18, 32'd5, "R6 reload");
    expectReg(8'h04, 32'h1, "R5 pending set");
    chk("R10 masked", 32'(irq), 32'h0);
    wrReg(8'h00, 32'h1);
    chk("R10 enabled", 32'(irq), 32'h1);
    wrReg(8'h04, 32'h0);
    expectReg(8'h04, 32'h1, "R3 zero write keeps");
    wrReg(8'h04, 32'h1);
    expectReg(8'h04, 32'h0, "R3 one write clears");
    chk("R10 after clear", 32'(irq), 32'h0);

    // channel 1: single mode halts even with reload bit
    wrReg(8'h24, 32'd3);
    wrReg(8'h20, 32'h87);
    expectReg(8'h28, 32'd3, "R11 load on start");
    oscOn = 1'b1; idle(3); oscOn = 1'b0;
    expectReg(8'h28, 32'd0, "R7 count zero");
    expectReg(8'h20, 32'h86, "R7 start cleared");
    expectReg(8'h04, 32'h2, "R5 pending ch1");
    chk("R10 ch1 not enabled", 32'(irq), 32'h0);
    oscOn = 1'b1; idle(4); oscOn = 1'b0;
    expectReg(8'h28, 32'd0, "R7 stays halted");
    wrReg(8'h04, 32'h3F);

    // channel 2: prescale by 4, one-shot
    wrReg(8'h34, 32'd10);
    wrReg(8'h30, 32'h25);
    expectReg(8'h38, 32'd10, "R11 load on start");
    oscOn = 1'b1; idle(8); oscOn = 1'b0;
    expectReg(8'h38, 32'd8, "R9 divide by four");
    wrReg(8'h39, 32'h77);
    expectReg(8'h38, 32'd8, "R2 unaligned write ignored");

    // channel 3: source select
    wrReg(8'h44, 32'd100);
    wrReg(8'h40, 32'h09);
    oscOn = 1'b1; idle(4); oscOn = 1'b0;
    expectReg(8'h48, 32'd100, "R8 other source ignored");
    slowOn = 1'b1; idle(6); slowOn = 1'b0;
    expectReg(8'h48, 32'd94, "R8 selected source");
    wrReg(8'h48, 32'd7);
    expectReg(8'h48, 32'd7, "R12 direct write");
    slowOn = 1'b1;
    wrReg(8'h48, 32'd50);
    slowOn = 1'b0;
    expectReg(8'h48, 32'd50, "R12 write beats tick");
    wrReg(8'h40, 32'h08);
    slowOn = 1'b1; idle(5); slowOn = 1'b0;
    expectReg(8'h48, 32'd50, "R4 stopped holds");
    wrReg(8'h40, 32'h09);
    expectReg(8'h48, 32'd50, "R11 nonzero kept");

    // channel 4: set beats clear in the same cycle
    wrReg(8'h50, 32'h07);
    oscOn = 1'b1;
    wrReg(8'h04, 32'h10);
    oscOn = 1'b0;
    busAddr = 8'h04; #1;
    chk("R3 set wins over clear", (busRdData >> 4) & 32'h1, 32'h1);
    wrReg(8'h04, 32'h3F);
    expectReg(8'h04, 32'h0, "R3 clear all");

    // mixed traffic against the model
    wrReg(8'h64, 32'd4);
    wrReg(8'h60, 32'h0F);
    wrReg(8'h00, 32'h3F);
    oscOn = 1'b1; slowOn = 1'b1;
    for (int i = 0; i < 20; i++) begin
      idle(10);
      wrReg(8'h04, 32'(lfsr));
      busAddr = 8'(8'h18 + 8'((i % 6) << 4));
    end
    oscOn = 1'b0; slowOn = 1'b0;
    idle(2);
    finishRun();
  end
endmodule